// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block generates the caption and extended-data waveform of a video encoder as digital luma codes for one chosen line of each field. A host loads two byte pairs, one for captions and one for extended data, through a small write port. Writing the second byte of a pair marks it as fresh. The next time the line for that service comes round, the block sends the pair. If a pair has not been refreshed since it was last sent, the block sends a null character pair instead. Each service has a ready flag that tells the host when a new pair may be loaded.

The block takes the current line number and the sample slot within the line from the encoder's timing counters. Slot 0 is the leading edge of horizontal sync. While the waveform is being sent, the block asserts an override flag and supplies the luma code that should replace the normal picture sample. The bit clock runs at about 0.5035 MHz. It comes from a phase accumulator clocked at the 27 MHz sample rate, so the timing error does not build up across the line.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset both ready flags read 1, the override flag reads 0 and the luma output holds the blanking code 64.
- R2: The write port uses wr_addr codes 0 = caption first byte, 1 = caption second byte, 2 = extended first byte, 3 = extended second byte. A second-byte write clears that service's ready flag from the next cycle. A first-byte write leaves the flag unchanged.
- R3: Captions go on line 21. Insertion starts when the slot input equals 284 on an enabled designated line: the override flag is 1 from the following cycle.
- R4: Extended data goes on line 284 when sys625 is 0 and on line 334 when sys625 is 1. Neither line is used in the other mode.
- R5: The waveform is 52 half-bit intervals. First come 14 intervals of run-in that alternate high and low, starting high. Then three start bits follow, each two intervals long, with values 0, 0, 1.
- R6: After the start bits the block sends the first byte and then the second byte, each least significant bit first, so bit 7 (the host-supplied odd parity) of each byte goes last. The block never alters parity.
- R7: A service line that has no refreshed pair sends the bytes 8'h80, 8'h80 (null with odd parity). Its ready flag stays 1.
- R8: A pair that was actually sent sets its ready flag back to 1 in the cycle after the last half-bit interval. A second-byte write that arrives while a null line is in flight stays pending after that line ends.
- R9: With a service's enable at 0, its line carries no insertion and its pending pair and ready flag are kept.
- R10: Each half-bit interval ends on the carry out of a 16-bit accumulator that adds 2444 per clock, starting from 0 at insertion start. The whole insertion therefore lasts 1393 to 1395 clocks.
- R11: While the override flag is 1 the luma output is 502 for a high level (50 IRE) or 64 for a low level. Otherwise it is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (27 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_num | input | 10 | Current line number |
| slot | input | 11 | Sample slot counted from the leading edge of horizontal sync |
| sys625 | input | 1 | 1 selects 625-line numbering for extended data |
| cap_en | input | 1 | Caption insertion enable |
| ext_en | input | 1 | Extended-data insertion enable |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 2 | Byte select (see R2) |
| wr_data | input | 8 | Byte written by the host |
| luma_ovr | output | 10 | Luma code that replaces the picture sample |
| ovr_valid | output | 1 | Override active |
| cap_ready | output | 1 | Caption pair may be loaded |
| ext_ready | output | 1 | Extended pair may be loaded |

## Verification
The override flag rises one clock after the start slot is sampled. The luma code then changes one clock after each accumulator carry. A ready flag falls one clock after a second-byte write and rises one clock after the final carry of a line that used its pair. The bench drives its inputs just after a rising edge, and its model advances on the same edge. It compares every output at the falling edge, so each comparison already takes these one-register delays into account. Line-level checks then confirm the start slot, the total duration and the ready flags after each line has fully ended.

// File: rtl/cc_ins_pkg.sv
package cc_ins_pkg;

  localparam int HB_RUNIN = 14;
  localparam int HB_START = 6;
  localparam int HB_TOTAL = 52;
  localparam logic [15:0] NULL_PAIR = 16'h8080;

  // accumulator increment for half-bit ticks, rounded to nearest
  function automatic longint half_bit_step(int acc_w, longint clk_hz, longint bit_hz);
    longint num;
    num = (2 * bit_hz) << acc_w;
    return (num + clk_hz / 2) / clk_hz;
  endfunction

  // level carried by half-bit interval hb for a given byte pair
  function automatic logic level_of(logic [5:0] hb, logic [15:0] bits);
    logic [5:0] d;
    d = hb - 6'd20;
    if (hb < 6'(HB_RUNIN))                 return ~hb[0];
    else if (hb < 6'(HB_RUNIN + HB_START)) return (hb >= 6'd18);
    else                                   return bits[d[4:1]];
  endfunction

endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
  parameter int ACC_W = 16,
  parameter logic [ACC_W-1:0] STEP = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic half_tick
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum       = {1'b0, acc} + {1'b0, STEP};
  assign half_tick = run & sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (run)   acc <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/cc_pair_store.sv
module cc_pair_store (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_first,
  input  logic        wr_second,
  input  logic [7:0]  wr_data,
  input  logic        release_pair,
  output logic [15:0] pair,
  output logic        pending
);
  logic [7:0] b_lo, b_hi;

  assign pair = {b_hi, b_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_lo    <= '0;
      b_hi    <= '0;
      pending <= 1'b0;
    end else begin
      if (wr_first)  b_lo <= wr_data;
      if (wr_second) b_hi <= wr_data;
      if (wr_second)         pending <= 1'b1;
      else if (release_pair) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
  import cc_ins_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int SLOT_W       = 11,
  parameter int LUMA_W       = 10,
  parameter int ACC_W        = 16,
  parameter longint CLK_HZ   = 27000000,
  parameter longint BIT_HZ   = 503500,
  parameter int START_SLOT   = 284,
  parameter int CAP_LINE     = 21,
  parameter int EXT_LINE_525 = 284,
  parameter int EXT_LINE_625 = 334,
  parameter int LOW_CODE     = 64,
  parameter int HIGH_CODE    = 502
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic [SLOT_W-1:0] slot,
  input  logic              sys625,
  input  logic              cap_en,
  input  logic              ext_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [LUMA_W-1:0] luma_ovr,
  output logic              ovr_valid,
  output logic              cap_ready,
  output logic              ext_ready
);
  localparam logic [ACC_W-1:0] STEP = ACC_W'(half_bit_step(ACC_W, CLK_HZ, BIT_HZ));
  localparam logic [5:0] HB_LAST = 6'(HB_TOTAL - 1);

  logic [1:0]  pending;
  logic [15:0] pair [2];
  logic [1:0]  release_pair;

  logic        active, cur_svc, cur_real;
  logic [5:0]  hb;
  logic [15:0] bits;
  logic        half_tick, finish, start, hit_cap, hit_ext, sel_svc;
  logic [LINE_W-1:0] ext_line;

  for (genvar s = 0; s < 2; s++) begin : g_svc
    logic wf, ws;
    assign wf = wr_en && (wr_addr == {1'(s), 1'b0});
    assign ws = wr_en && (wr_addr == {1'(s), 1'b1});
    assign release_pair[s] = finish && (cur_svc == 1'(s)) && cur_real;
    cc_pair_store u_store (
      .clk(clk), .rst_n(rst_n), .wr_first(wf), .wr_second(ws),
      .wr_data(wr_data), .release_pair(release_pair[s]),
      .pair(pair[s]), .pending(pending[s])
    );
  end

  cc_bit_timer #(.ACC_W(ACC_W), .STEP(STEP)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(start), .run(active), .half_tick(half_tick)
  );

  assign ext_line = sys625 ? LINE_W'(EXT_LINE_625) : LINE_W'(EXT_LINE_525);
  assign hit_cap  = cap_en && (line_num == LINE_W'(CAP_LINE));
  assign hit_ext  = ext_en && (line_num == ext_line) && !hit_cap;
  assign sel_svc  = hit_ext;
  assign start    = !active && (slot == SLOT_W'(START_SLOT)) && (hit_cap || hit_ext);
  assign finish   = active && half_tick && (hb == HB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      hb       <= '0;
      cur_svc  <= 1'b0;
      cur_real <= 1'b0;
      bits     <= NULL_PAIR;
    end else if (start) begin
      active   <= 1'b1;
      hb       <= '0;
      cur_svc  <= sel_svc;
      cur_real <= pending[sel_svc];
      bits     <= pending[sel_svc] ? pair[sel_svc] : NULL_PAIR;
    end else if (active && half_tick) begin
      if (finish) active <= 1'b0;
      else        hb <= hb + 6'd1;
    end
  end

  assign ovr_valid = active;
  assign luma_ovr  = (active && level_of(hb, bits)) ? LUMA_W'(HIGH_CODE) : LUMA_W'(LOW_CODE);
  assign cap_ready = ~pending[0];
  assign ext_ready = ~pending[1];
endmodule

// File: rtl/cc_line_inserter_chk.sv
module cc_line_inserter_chk #(
  parameter int LINE_W     = 10,
  parameter int SLOT_W     = 11,
  parameter int LUMA_W     = 10,
  parameter int START_SLOT = 284,
  parameter int CAP_LINE   = 21,
  parameter int LOW_CODE   = 64,
  parameter int HIGH_CODE  = 502,
  parameter int MAX_LEN    = 1396
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line_num,
  input logic [SLOT_W-1:0] slot,
  input logic              cap_en,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [LUMA_W-1:0] luma_ovr,
  input logic              ovr_valid,
  input logic              cap_ready,
  input logic              ext_ready
);
  logic [11:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (ovr_valid) run_len <= run_len + 12'd1;
    else                run_len <= '0;
  end

  p_ready_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> !cap_ready);

  p_ext_ready_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> !ext_ready);

  p_cap_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_valid && cap_en && line_num == LINE_W'(CAP_LINE) && slot == SLOT_W'(START_SLOT))
      |=> ovr_valid);

  p_runin_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_valid) |-> luma_ovr == LUMA_W'(HIGH_CODE));

  p_ready_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_ready) |-> $fell(ovr_valid));

  p_bounded_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_valid |-> run_len < 12'(MAX_LEN));

  p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_valid |-> luma_ovr == LUMA_W'(LOW_CODE));

  p_levels_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_valid |-> (luma_ovr == LUMA_W'(HIGH_CODE) || luma_ovr == LUMA_W'(LOW_CODE)));
endmodule

bind cc_line_inserter cc_line_inserter_chk #(
  .LINE_W(LINE_W), .SLOT_W(SLOT_W), .LUMA_W(LUMA_W), .START_SLOT(START_SLOT),
  .CAP_LINE(CAP_LINE), .LOW_CODE(LOW_CODE), .HIGH_CODE(HIGH_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_num(line_num), .slot(slot), .cap_en(cap_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .luma_ovr(luma_ovr), .ovr_valid(ovr_valid),
  .cap_ready(cap_ready), .ext_ready(ext_ready)
);

// File: tb/cc_line_inserter_test.sv
module cc_line_inserter_test;
  localparam int LINE_SLOTS = 1716;
  localparam int HI = 502;
  localparam int LO = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic [9:0] line_num = 0;
  logic [10:0] slot = 0;
  logic sys625 = 0, cap_en = 1, ext_en = 1, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [9:0] luma_ovr;
  logic ovr_valid, cap_ready, ext_ready;

  int compared = 0, mismatched = 0, cycles = 0;
  string req = "R1";

  always #10 clk = ~clk;

  cc_line_inserter uut (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .slot(slot), .sys625(sys625),
    .cap_en(cap_en), .ext_en(ext_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .luma_ovr(luma_ovr), .ovr_valid(ovr_valid),
    .cap_ready(cap_ready), .ext_ready(ext_ready)
  );

  // behavioural reference model
  longint step;
  int m_acc, m_hb, m_svc;
  bit m_active, m_real;
  bit [15:0] m_bits;
  bit m_pend [2];
  bit [7:0] m_lo [2];
  bit [7:0] m_hi [2];

  initial step = ((2 * 64'd503500) * 65536 + 13500000) / 27000000;

  function automatic int model_luma();
    bit lvl;
    if (!m_active) return LO;
    if (m_hb < 14)      lvl = (m_hb % 2 == 0);
    else if (m_hb < 20) lvl = ((m_hb - 14) / 2 == 2);
    else                lvl = m_bits[(m_hb - 20) / 2];
    return lvl ? HI : LO;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_acc = 0; m_hb = 0; m_svc = 0; m_real = 0; m_bits = 16'h8080;
      for (int s = 0; s < 2; s++) begin m_pend[s] = 0; m_lo[s] = 0; m_hi[s] = 0; end
    end else begin
      int extl;
      bit capl, extm;
      extl = sys625 ? 334 : 284;
      capl = cap_en && line_num == 21;
      extm = ext_en && line_num == extl;
      if (m_active) begin
        m_acc = m_acc + int'(step);
        if (m_acc >= 65536) begin
          m_acc = m_acc - 65536;
          if (m_hb == 51) begin
            m_active = 0;
            if (m_real) m_pend[m_svc] = 0;
          end else m_hb++;
        end
      end else if (slot == 284 && (capl || extm)) begin
        m_svc = capl ? 0 : 1;
        m_active = 1; m_acc = 0; m_hb = 0;
        m_real = m_pend[m_svc];
        m_bits = m_real ? {m_hi[m_svc], m_lo[m_svc]} : 16'h8080;
      end
      if (wr_en) begin
        if (wr_addr[0]) begin m_hi[wr_addr[1]] = wr_data; m_pend[wr_addr[1]] = 1; end
        else m_lo[wr_addr[1]] = wr_data;
      end
    end
  end

  int vcnt, first_slot;
  bit prev_v;

  always @(negedge clk) begin
    int exp_l;
    if (rst_n) begin
      exp_l = model_luma();
      compared++;
      if (luma_ovr != 10'(exp_l) || ovr_valid != m_active ||
          cap_ready != !m_pend[0] || ext_ready != !m_pend[1]) begin
        mismatched++;
        $display("FAIL %s: luma/valid/rdy act %0d/%0b/%0b%0b exp %0d/%0b/%0b%0b",
                 req, luma_ovr, ovr_valid, cap_ready, ext_ready,
                 exp_l, m_active, !m_pend[0], !m_pend[1]);
      end
    end
    if (ovr_valid && !prev_v) first_slot = int'(slot);
    if (ovr_valid) vcnt++;
    prev_v = ovr_valid;
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      compared++; mismatched++;
      $display("FAIL watchdog: act %0d cycles exp below 200000", cycles);
      report();
    end
  end

  task automatic check(string r, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: act %0d exp %0d", r, act, exp);
    end
  endtask

  task automatic hw(int a, int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic run_line(int ln, int wslot = -1, int wa = 0, int wd = 0);
    line_num = 10'(ln);
    vcnt = 0; first_slot = -1;
    for (int s = 0; s < LINE_SLOTS; s++) begin
      slot = 11'(s);
      wr_en = (s == wslot); wr_addr = 2'(wa); wr_data = 8'(wd);
      @(posedge clk); #1;
    end
    wr_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    req = "R1";
    check("R1 ready cap", int'(cap_ready), 1);
    check("R1 ready ext", int'(ext_ready), 1);
    check("R1 valid", int'(ovr_valid), 0);
    check("R1 luma", int'(luma_ovr), LO);
    @(posedge clk); #1;
    rst_n = 1;

    req = "R2";
    hw(0, 8'h41);
    @(negedge clk); check("R2 first byte keeps ready", int'(cap_ready), 1);
    @(posedge clk); #1;
    hw(1, 8'hC2);
    @(negedge clk); check("R2 second byte clears ready", int'(cap_ready), 0);
    @(posedge clk); #1;

    req = "R3";
    run_line(20);
    check("R3 no insertion on line 20", vcnt, 0);
    req = "R6";
    run_line(21);
    check("R3 start slot", first_slot, 285);
    check("R10 duration ok", int'(vcnt >= 1393 && vcnt <= 1395), 1);
    check("R8 ready back", int'(cap_ready), 1);

    req = "R7";
    run_line(21);
    check("R7 null line sent", int'(vcnt > 0), 1);
    check("R7 ready stays", int'(cap_ready), 1);

    req = "R4";
    hw(2, 8'h55); hw(3, 8'hAA);
    run_line(334);
    check("R4 334 unused in 525", vcnt, 0);
    check("R4 pending kept", int'(ext_ready), 0);
    run_line(284);
    check("R4 line 284 in 525", int'(vcnt > 0), 1);
    check("R8 ext ready back", int'(ext_ready), 1);
    sys625 = 1;
    hw(2, 8'hFF); hw(3, 8'h01);
    run_line(284);
    check("R4 284 unused in 625", vcnt, 0);
    run_line(334);
    check("R4 line 334 in 625", int'(vcnt > 0), 1);
    check("R4 ext ready back", int'(ext_ready), 1);

    req = "R9";
    cap_en = 0;
    hw(0, 8'h80); hw(1, 8'h7F);
    run_line(21);
    check("R9 disabled no insert", vcnt, 0);
    check("R9 pending kept", int'(cap_ready), 0);
    cap_en = 1;
    req = "R5";
    run_line(21);
    check("R9 sent after enable", int'(cap_ready), 1);

    req = "R8";
    run_line(21, 600, 1, 8'h3C);
    check("R8 mid-null write stays pending", int'(cap_ready), 0);
    req = "R11";
    run_line(21);
    check("R11 sent pair releases", int'(cap_ready), 1);

    report();
  end
endmodule